// File: doc/BRIEF.md
# Main Clock Loss Detector with Fallback Control

This block watches a main clock for loss and for restart, using only a free-running on-chip oscillator as its own clock. The main clock is brought into the oscillator domain through a two-stage synchronizer. An edge watcher then decides whether the main clock is running or halted. When the main clock halts, the block can do one of two things. In interrupt mode it raises an interrupt and, if the main clock itself drives the CPU, moves the CPU clock selection over to the on-chip oscillator. In reset mode it asks for a system reset. A restart of the main clock is reported through the same sticky flag.

Software controls the block through one byte-wide register on a simple write bus. The register reads back combinationally. Writes take effect only while a write-protect release input is high. A separate clock-modification lock input freezes the detection enable. A status input says whether the PLL is currently the CPU clock source, and in that case the automatic switch is suppressed.

The edge watcher has two states, RUN and HALT. RUN to HALT is taken on quiet timeout. HALT to RUN is taken on an edge quota. HALT to HALT with the edge count cleared is taken on a quiet relapse. The sticky flag is a second two-state machine, CLEAR and LATCHED. CLEAR to LATCHED is taken on a detection event. LATCHED to CLEAR is taken on a software clear or on a detection reset.

Top module: `clkfail_ctrl`

## Requirements
- R1: A register write (bus_wr high on a clock edge) changes the register only while wr_unlock is high. With wr_unlock low the write leaves every bit unchanged.
- R2: Register layout: bit 0 is the detection enable, bit 1 the clock select (1 = on-chip oscillator), bit 2 the sticky flag, bit 3 the read-only halted monitor, bits 5:4 always read 0, bit 6 is a plain reserved storage bit, and bit 7 is the action (1 = interrupt, 0 = reset request). After power-on reset the register reads 0x00.
- R3: The main clock passes through two flops in the oscillator domain. Sixteen consecutive oscillator cycles without a synchronized rising edge put the watcher into HALT, and bit 3 then reads 1.
- R4: In HALT, eight rising edges return the watcher to RUN (bit 3 reads 0). Sixteen edge-free cycles in HALT discard the edges counted so far.
- R5: While enabled, each halt or restart event sets the flag. A one-cycle irq pulse is produced only when the flag was 0 and bit 7 is 1. An event while the flag is already 1 gives no pulse.
- R6: The flag clears only when software writes 0 to bit 2. Writing 1 to bit 2 has no effect, and the irq pulse does not clear the flag. A detection event in the same cycle as a clear leaves the flag at 1.
- R7: On a halt event with enable = 1, action = 1 and pll_sel = 0, bit 1 (clk_sel) is set to 1 automatically.
- R8: On a halt event while pll_sel = 1, clk_sel is left unchanged, and the interrupt is still raised if the flag was 0.
- R9: On a halt event with enable = 1 and action = 0, rst_req pulses high for one cycle.
- R10: While clk_lock is high, writes do not change bit 0. Other bits are written normally.
- R11: A stop_rst pulse clears the flag and any pending pulses. It leaves bits 0, 1, 6 and 7 unchanged.
- R12: With bit 0 at 0, halts and restarts still move the monitor bit. They do not set the flag, do not raise irq or rst_req, and do not change clk_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running on-chip oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stop_rst | input | 1 | Synchronous reset caused by a halt detection, active high |
| mclk | input | 1 | Main clock being monitored (asynchronous) |
| pll_sel | input | 1 | High while the PLL drives the CPU |
| wr_unlock | input | 1 | Write-protect release |
| clk_lock | input | 1 | Clock-modification lock; freezes the enable bit |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| clk_sel | output | 1 | CPU clock source select, 1 = on-chip oscillator |
| irq | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is an event that arrives while the flag is already set. It needs a full halt followed by a full restart with no software clear in between. It must also be told apart from the interrupt that a restart raises once the flag has been cleared. The stimulus therefore drives the main clock through halt, restart, clear and halt again, with the PLL status and the lock input held at chosen values across those transitions. A behavioural model tracks quiet-cycle and edge counts and is compared with the outputs on every cycle.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;

    typedef enum logic [0:0] {
        DET_RUN  = 1'b0,
        DET_HALT = 1'b1
    } det_state_e;

    typedef enum logic [0:0] {
        FLG_CLEAR   = 1'b0,
        FLG_LATCHED = 1'b1
    } flag_state_e;

    localparam int BIT_EN   = 0;
    localparam int BIT_SEL  = 1;
    localparam int BIT_FLAG = 2;
    localparam int BIT_MON  = 3;
    localparam int BIT_RSV  = 6;
    localparam int BIT_ACT  = 7;
    localparam int REG_W    = 8;

endpackage

// File: rtl/clkfail_sync.sv
module clkfail_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shift_q <= '0;
                else        shift_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shift_q <= '0;
                else        shift_q <= {shift_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = shift_q[STAGES-1];
endmodule

// File: rtl/clkfail_watch.sv
module clkfail_watch
    import clkfail_pkg::*;
#(
    parameter int STOP_CYC      = 16,
    parameter int RESTART_EDGES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic halted,
    output logic stop_hit,
    output logic restart_hit
);
    localparam int IW = (STOP_CYC > 1) ? $clog2(STOP_CYC) : 1;
    localparam int EW = (RESTART_EDGES > 1) ? $clog2(RESTART_EDGES) : 1;
    localparam logic [IW-1:0] LAST_IDLE = IW'(STOP_CYC - 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(RESTART_EDGES - 1);

    det_state_e    state_q, state_d;
    logic [IW-1:0] idle_q, idle_d;
    logic [EW-1:0] ecnt_q, ecnt_d;
    logic          lvl_d;
    logic          rise;

    assign rise = lvl & ~lvl_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_RUN;
            idle_q  <= '0;
            ecnt_q  <= '0;
            lvl_d   <= 1'b0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
            ecnt_q  <= ecnt_d;
            lvl_d   <= lvl;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idle_d  = idle_q;
        ecnt_d  = ecnt_q;
        unique case (state_q)
            DET_RUN: begin
                if (rise) begin
                    idle_d = '0;
                end else if (idle_q == LAST_IDLE) begin
                    state_d = DET_HALT;          // quiet timeout
                    idle_d  = '0;
                    ecnt_d  = '0;
                end else begin
                    idle_d = idle_q + 1'b1;
                end
            end
            DET_HALT: begin
                if (rise) begin
                    idle_d = '0;
                    if (ecnt_q == LAST_EDGE) begin
                        state_d = DET_RUN;       // edge quota
                        ecnt_d  = '0;
                    end else begin
                        ecnt_d = ecnt_q + 1'b1;
                    end
                end else if (idle_q == LAST_IDLE) begin
                    idle_d = '0;                 // quiet relapse
                    ecnt_d = '0;
                end else begin
                    idle_d = idle_q + 1'b1;
                end
            end
            default: begin
                state_d = DET_RUN;
                idle_d  = '0;
                ecnt_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        halted      = (state_q == DET_HALT);
        stop_hit    = (state_q == DET_RUN)  && (state_d == DET_HALT);
        restart_hit = (state_q == DET_HALT) && (state_d == DET_RUN);
    end

    assert_idle_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q <= LAST_IDLE);
    assert_edge_keeps_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_RUN && rise) |=> state_q == DET_RUN);
    assert_quiet_keeps_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DET_HALT && !rise) |=> state_q == DET_HALT);
endmodule

// File: rtl/clkfail_regs.sv
module clkfail_regs
    import clkfail_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_rst,
    input  logic             bus_wr,
    input  logic             wr_unlock,
    input  logic             clk_lock,
    input  logic [REG_W-1:0] wdata,
    input  logic             pll_sel,
    input  logic             halted,
    input  logic             stop_hit,
    input  logic             restart_hit,
    output logic [REG_W-1:0] rdata,
    output logic             clk_sel,
    output logic             irq,
    output logic             rst_req
);
    flag_state_e fst_q, fst_d;
    logic en_q, sel_q, act_q, rsv_q;
    logic sel_d, irq_q, irq_d, rreq_q, rreq_d;
    logic wr_ok, evt, sw_clear;
    logic unused_wbits;

    assign unused_wbits = ^wdata[5:3];
    assign wr_ok    = bus_wr & wr_unlock;
    assign evt      = en_q & (stop_hit | restart_hit);
    assign sw_clear = wr_ok & ~wdata[BIT_FLAG];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fst_q  <= FLG_CLEAR;
            en_q   <= 1'b0;
            sel_q  <= 1'b0;
            act_q  <= 1'b0;
            rsv_q  <= 1'b0;
            irq_q  <= 1'b0;
            rreq_q <= 1'b0;
        end else if (stop_rst) begin
            fst_q  <= FLG_CLEAR;
            irq_q  <= 1'b0;
            rreq_q <= 1'b0;
        end else begin
            fst_q  <= fst_d;
            sel_q  <= sel_d;
            irq_q  <= irq_d;
            rreq_q <= rreq_d;
            if (wr_ok) begin
                if (!clk_lock) en_q <= wdata[BIT_EN];
                act_q <= wdata[BIT_ACT];
                rsv_q <= wdata[BIT_RSV];
            end
        end
    end

    // flag transitions
    always_comb begin
        fst_d = fst_q;
        unique case (fst_q)
            FLG_CLEAR:   if (evt) fst_d = FLG_LATCHED;
            FLG_LATCHED: if (sw_clear && !evt) fst_d = FLG_CLEAR;
            default:     fst_d = FLG_CLEAR;
        endcase
    end

    // outputs and select
    always_comb begin
        sel_d = sel_q;
        if (wr_ok) sel_d = wdata[BIT_SEL];
        if (en_q && act_q && stop_hit && !pll_sel) sel_d = 1'b1;
        irq_d  = evt && act_q && (fst_q == FLG_CLEAR);
        rreq_d = en_q && !act_q && stop_hit;
    end

    always_comb begin
        rdata           = '0;
        rdata[BIT_EN]   = en_q;
        rdata[BIT_SEL]  = sel_q;
        rdata[BIT_FLAG] = (fst_q == FLG_LATCHED);
        rdata[BIT_MON]  = halted;
        rdata[BIT_RSV]  = rsv_q;
        rdata[BIT_ACT]  = act_q;
    end

    assign clk_sel = sel_q;
    assign irq     = irq_q;
    assign rst_req = rreq_q;

    assert_locked_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && wr_unlock) |=> $stable(act_q) && $stable(rsv_q));
    assert_irq_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (fst_q == FLG_LATCHED) && ($past(fst_q) == FLG_CLEAR));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fst_q == FLG_LATCHED && !(bus_wr && wr_unlock && !wdata[BIT_FLAG]) && !stop_rst)
        |=> fst_q == FLG_LATCHED);
    assert_pll_keeps_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_sel && !(bus_wr && wr_unlock)) |=> $stable(sel_q));
    assert_lock_freezes_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lock |=> $stable(en_q));
    assert_detrst_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rst |=> $stable(en_q) && $stable(act_q) && $stable(sel_q) && $stable(rsv_q));
    assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !stop_rst) |=> !irq_q && !rreq_q);
endmodule

// File: rtl/clkfail_ctrl.sv
module clkfail_ctrl
    import clkfail_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STOP_CYC      = 16,
    parameter int RESTART_EDGES = 8
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             stop_rst,
    input  logic             mclk,
    input  logic             pll_sel,
    input  logic             wr_unlock,
    input  logic             clk_lock,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             clk_sel,
    output logic             irq,
    output logic             rst_req
);
    logic mclk_s, halted, stop_hit, restart_hit;

    clkfail_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .d     (mclk),
        .q     (mclk_s)
    );

    clkfail_watch #(.STOP_CYC(STOP_CYC), .RESTART_EDGES(RESTART_EDGES)) u_watch (
        .clk         (clk_osc),
        .rst_n       (rst_n),
        .lvl         (mclk_s),
        .halted      (halted),
        .stop_hit    (stop_hit),
        .restart_hit (restart_hit)
    );

    clkfail_regs u_regs (
        .clk         (clk_osc),
        .rst_n       (rst_n),
        .stop_rst    (stop_rst),
        .bus_wr      (bus_wr),
        .wr_unlock   (wr_unlock),
        .clk_lock    (clk_lock),
        .wdata       (bus_wdata),
        .pll_sel     (pll_sel),
        .halted      (halted),
        .stop_hit    (stop_hit),
        .restart_hit (restart_hit),
        .rdata       (bus_rdata),
        .clk_sel     (clk_sel),
        .irq         (irq),
        .rst_req     (rst_req)
    );
endmodule

// File: tb/sim_clkfail_ctrl.sv
module sim_clkfail_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_rst = 1'b0;
    logic       mclk = 1'b0;
    logic       pll_sel = 1'b0;
    logic       wr_unlock = 1'b0;
    logic       clk_lock = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       clk_sel, irq, rst_req;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    int rreq_cnt = 0;
    bit mrun = 1'b0;
    int mdiv = 0;
    bit done = 1'b0;

    // reference model state
    int  mq[$];
    bit  m_en, m_sel, m_flag, m_act, m_rsv, m_mon, m_irq, m_rreq;
    int  m_quiet, m_edges;

    always #5 clk = ~clk;

    clkfail_ctrl u0 (
        .clk_osc(clk), .rst_n(rst_n), .stop_rst(stop_rst), .mclk(mclk),
        .pll_sel(pll_sel), .wr_unlock(wr_unlock), .clk_lock(clk_lock),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_sel(clk_sel), .irq(irq), .rst_req(rst_req)
    );

    // main clock source: one edge every four oscillator cycles when running
    always @(negedge clk) begin
        if (mrun) begin
            mdiv = mdiv + 1;
            if (mdiv >= 2) begin
                mclk = ~mclk;
                mdiv = 0;
            end
        end else begin
            mclk = 1'b0;
            mdiv = 0;
        end
    end

    // behavioural reference, updated on every edge
    always @(posedge clk) begin
        bit seen, stop_e, rest_e, ev, wr;
        bit n_sel, n_flag;
        if (!rst_n) begin
            mq = '{0, 0, 0, 0};
            {m_en, m_sel, m_flag, m_act, m_rsv, m_mon, m_irq, m_rreq} = '0;
            m_quiet = 0;
            m_edges = 0;
        end else begin
            mq.push_back(int'(mclk));
            void'(mq.pop_front());
            seen = (mq[1] == 1) && (mq[0] == 0);
            stop_e = 1'b0;
            rest_e = 1'b0;
            if (!m_mon) begin
                if (seen) m_quiet = 0;
                else begin
                    m_quiet++;
                    if (m_quiet == 16) begin
                        stop_e = 1'b1; m_mon = 1'b1; m_quiet = 0; m_edges = 0;
                    end
                end
            end else begin
                if (seen) begin
                    m_quiet = 0;
                    m_edges++;
                    if (m_edges == 8) begin
                        rest_e = 1'b1; m_mon = 1'b0; m_edges = 0;
                    end
                end else begin
                    m_quiet++;
                    if (m_quiet == 16) begin m_quiet = 0; m_edges = 0; end
                end
            end
            if (stop_rst) begin
                m_flag = 1'b0; m_irq = 1'b0; m_rreq = 1'b0;
            end else begin
                ev = m_en && (stop_e || rest_e);
                wr = bus_wr && wr_unlock;
                m_irq  = ev && m_act && !m_flag;
                m_rreq = m_en && !m_act && stop_e;
                n_sel = m_sel;
                if (wr) n_sel = bus_wdata[1];
                if (m_en && m_act && stop_e && !pll_sel) n_sel = 1'b1;
                n_flag = m_flag;
                if (wr && !bus_wdata[2]) n_flag = 1'b0;
                if (ev) n_flag = 1'b1;
                if (wr) begin
                    if (!clk_lock) m_en = bus_wdata[0];
                    m_act = bus_wdata[7];
                    m_rsv = bus_wdata[6];
                end
                m_sel  = n_sel;
                m_flag = n_flag;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 rdata model", bus_rdata,
                {m_act, m_rsv, 2'b00, m_mon, m_flag, m_sel, m_en});
            chk("R5 irq model", {7'd0, irq}, {7'd0, m_irq});
            chk("R7 clk_sel model", {7'd0, clk_sel}, {7'd0, m_sel});
            chk("R9 rst_req model", {7'd0, rst_req}, {7'd0, m_rreq});
            if (irq) irq_cnt++;
            if (rst_req) rreq_cnt++;
        end
    end

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset value", bus_rdata, 8'h00);
        chk("R2 reset outputs", {5'd0, clk_sel, irq, rst_req}, 8'h00);

        mrun = 1'b1;
        idle(30);
        write_reg(8'h81);
        chk("R1 protected write ignored", bus_rdata, 8'h00);

        wr_unlock = 1'b1;
        write_reg(8'hF5);
        chk("R2 bits 5:4 read zero, R6 write one keeps flag", bus_rdata, 8'hC1);

        base = irq_cnt;
        mrun = 1'b0;
        idle(30);
        chk("R3 halt sets monitor, R7 auto select", bus_rdata, 8'hCF);
        chk("R5 one irq on halt", 8'(irq_cnt - base), 8'd1);

        mrun = 1'b1;
        idle(60);
        chk("R4 restart clears monitor", bus_rdata, 8'hC7);
        chk("R5 no irq while flag set", 8'(irq_cnt - base), 8'd1);

        write_reg(8'hC7);
        chk("R6 writing one keeps flag", bus_rdata, 8'hC7);
        write_reg(8'hC3);
        chk("R6 writing zero clears flag", bus_rdata, 8'hC3);

        write_reg(8'hC1);
        pll_sel = 1'b1;
        base = irq_cnt;
        mrun = 1'b0;
        idle(30);
        chk("R8 select held under PLL", bus_rdata, 8'hCD);
        chk("R8 irq still raised", 8'(irq_cnt - base), 8'd1);

        clk_lock = 1'b1;
        write_reg(8'hC0);
        chk("R10 enable frozen by lock", bus_rdata, 8'hC9);
        clk_lock = 1'b0;
        pll_sel = 1'b0;

        base = irq_cnt;
        mrun = 1'b1;
        idle(60);
        chk("R5 restart sets cleared flag", bus_rdata, 8'hC5);
        chk("R5 irq on restart", 8'(irq_cnt - base), 8'd1);

        write_reg(8'h43);
        chk("R2 action reset mode written", bus_rdata, 8'h43);
        base = irq_cnt;
        mrun = 1'b0;
        idle(30);
        chk("R9 one reset request", 8'(rreq_cnt), 8'd1);
        chk("R9 no irq in reset mode", 8'(irq_cnt - base), 8'd0);
        chk("R9 flag and monitor set", bus_rdata, 8'h4F);

        @(negedge clk);
        stop_rst = 1'b1;
        @(negedge clk);
        stop_rst = 1'b0;
        chk("R11 detection reset keeps control bits", bus_rdata, 8'h4B);

        write_reg(8'h80);
        base = irq_cnt;
        mrun = 1'b1;
        idle(60);
        chk("R12 disabled restart leaves flag", bus_rdata, 8'h80);
        mrun = 1'b0;
        idle(30);
        chk("R12 disabled halt only moves monitor", bus_rdata, 8'h88);
        chk("R12 no irq when disabled", 8'(irq_cnt - base), 8'd0);
        chk("R12 no reset request when disabled", 8'(rreq_cnt), 8'd1);

        idle(2);
        finish_run();
    end
endmodule